// File: doc/BRIEF.md
# Skewed Matrix Storage Mapper

This block places an N x N matrix across N memory modules with a circular skew, so that a whole row or a whole column can be read in one parallel access. Element (i, j), with indices counted from zero, lives in module (i + j) mod N at local offset i. Each row is therefore shifted one module further to the right than the row above it. No two elements of the same row share a module, and no two elements of the same column do.

A request gives an access mode (row or column), a vector index and a start strobe. On the next clock the block presents one local offset per module and a rotate amount. The module read data comes back on a flat bus with module k in lane k. A barrel rotator inside the block turns that bus left by the rotate amount, so that output lane j carries element j of the requested vector. The memories sit outside the block, and their read data is taken as valid in the same cycle that the offsets are presented.

Top module: `skew_mapper`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, valid is 0 and every module offset and the rotate amount are 0.
- R2: In row mode (mode = 0), on the clock after a start with index r, every module offset equals r.
- R3: In column mode (mode = 1), on the clock after a start with index c, module k offset equals (k - c) mod N. The N offsets are then all different.
- R4: On the clock after any start, the rotate amount equals the requested index in both modes.
- R5: Output lane j always equals read-data lane (j + rot) mod N, combinationally. This is a left rotation of the read-data bus by the registered rotate amount.
- R6: valid is 1 in exactly the cycles that follow a clock edge where start was 1.
- R7: When start is 0 at a clock edge, the offsets and the rotate amount keep their values across that edge.
- R8: With memories filled under the skew rule, a row-r access delivers elements (r, 0) to (r, N-1) on lanes 0 to N-1. A column-c access delivers elements (0, c) to (N-1, c) on lanes 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a vector access |
| mode | input | 1 | 0 selects a row, 1 selects a column |
| idx | input | IW | Row or column index of the vector |
| rd_data | input | LANES*DW | Module read data, module k in lane k |
| valid | output | 1 | Offsets and aligned vector belong to a request |
| mod_addr | output | LANES*IW | Local offset for each module, module k in slice k |
| rot_amt | output | IW | Left rotation applied by the aligner |
| vec_out | output | LANES*DW | Aligned vector, element j in lane j |

## Verification
The assertions check on every cycle that valid follows start, that the offsets and the rotation follow the index in each mode, that they hold while no start arrives, and that column offsets never collide in a module. The end-to-end property cannot be seen by any assertion on the block alone. That property is that skewed memory contents come out in element order after the rotator. The bench shows it by running every row and column, back-to-back requests and a mid-run reset against its own memory model.

// File: rtl/skew_mapper.sv
module skew_mapper #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int IW    = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  mode,
  input  logic [IW-1:0]         idx,
  input  logic [LANES*DW-1:0]   rd_data,
  output logic                  valid,
  output logic [LANES*IW-1:0]   mod_addr,
  output logic [IW-1:0]         rot_amt,
  output logic [LANES*DW-1:0]   vec_out
);

  logic [LANES*IW-1:0] addr_q;
  logic [IW-1:0]       rot_q;
  logic                valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rot_q <= '0;
    else if (start) rot_q <= idx;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mod
    logic [IW-1:0] kk;
    logic [IW-1:0] off_next;
    assign kk       = IW'(k);
    assign off_next = mode ? IW'(kk - idx) : idx;
    always_ff @(posedge clk) begin
      if (!rst_n)     addr_q[k*IW +: IW] <= '0;
      else if (start) addr_q[k*IW +: IW] <= off_next;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IW-1:0] src;
    assign src = IW'(IW'(j) + rot_q);
    assign vec_out[j*DW +: DW] = rd_data[src*DW +: DW];
  end

  assign valid    = valid_q;
  assign mod_addr = addr_q;
  assign rot_amt  = rot_q;

endmodule

// File: rtl/skew_mapper_chk.sv
module skew_mapper_chk #(
  parameter int LANES = 4,
  parameter int IW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                mode,
  input logic [IW-1:0]       idx,
  input logic                valid,
  input logic [LANES*IW-1:0] mod_addr,
  input logic [IW-1:0]       rot_amt
);

  function automatic logic all_equal(input logic [LANES*IW-1:0] a, input logic [IW-1:0] v);
    logic ok = 1'b1;
    for (int k = 0; k < LANES; k++) if (a[k*IW +: IW] != v) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic col_ok(input logic [LANES*IW-1:0] a, input logic [IW-1:0] c);
    logic ok = 1'b1;
    for (int k = 0; k < LANES; k++) if (a[k*IW +: IW] != IW'(IW'(k) - c)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic distinct(input logic [LANES*IW-1:0] a);
    logic ok = 1'b1;
    for (int p = 0; p < LANES; p++)
      for (int q = p + 1; q < LANES; q++)
        if (a[p*IW +: IW] == a[q*IW +: IW]) ok = 1'b0;
    return ok;
  endfunction

  p_valid_hi_r6: assert property (@(posedge clk) disable iff (!rst_n) start |=> valid);
  p_valid_lo_r6: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !valid);
  p_row_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode) |=> all_equal(mod_addr, $past(idx)));
  p_col_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode) |=> col_ok(mod_addr, $past(idx)));
  p_col_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode) |=> distinct(mod_addr));
  p_rot_r4: assert property (@(posedge clk) disable iff (!rst_n) start |=> rot_amt == $past(idx));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(mod_addr) && $stable(rot_amt)));

endmodule

bind skew_mapper skew_mapper_chk #(.LANES(LANES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx(idx),
  .valid(valid), .mod_addr(mod_addr), .rot_amt(rot_amt)
);

// File: tb/tb_skew_mapper.sv
module tb_skew_mapper;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int IW    = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                mode = 1'b0;
  logic [IW-1:0]       idx = '0;
  logic [LANES*DW-1:0] rd_data;
  logic                valid;
  logic [LANES*IW-1:0] mod_addr;
  logic [IW-1:0]       rot_amt;
  logic [LANES*DW-1:0] vec_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  skew_mapper #(.LANES(LANES), .DW(DW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx(idx),
    .rd_data(rd_data), .valid(valid), .mod_addr(mod_addr),
    .rot_amt(rot_amt), .vec_out(vec_out)
  );

  // skewed memory: element (i,j) in module (i+j)%N at offset i, value i*16+j
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      int off;
      int col;
      off = int'(mod_addr[k*IW +: IW]);
      col = (k - off + LANES) % LANES;
      rd_data[k*DW +: DW] = DW'(off * 16 + col);
    end
  end

  // reference model
  int  m_valid = 0;
  int  m_mode  = 0;
  int  m_idx   = 0;
  int  m_addr[LANES];
  int  m_fresh = 0;
  int  m_reset = 1;

  initial for (int k = 0; k < LANES; k++) m_addr[k] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_idx = 0; m_fresh = 0; m_reset = 1;
      for (int k = 0; k < LANES; k++) m_addr[k] = 0;
    end else begin
      m_reset = 0;
      m_fresh = start ? 1 : 0;
      m_valid = start ? 1 : 0;
      if (start) begin
        m_mode = int'(mode);
        m_idx  = int'(idx);
        for (int k = 0; k < LANES; k++)
          m_addr[k] = mode ? (k - int'(idx) + LANES) % LANES : int'(idx);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string ta;
    ta = m_reset ? "R1 offset" : (m_fresh ? (m_mode ? "R3 column offset" : "R2 row offset") : "R7 hold offset");
    chk(m_reset ? "R1 valid" : "R6 valid", int'(valid), m_valid);
    chk(m_reset ? "R1 rot" : (m_fresh ? "R4 rot" : "R7 hold rot"), int'(rot_amt), m_idx);
    for (int k = 0; k < LANES; k++) chk(ta, int'(mod_addr[k*IW +: IW]), m_addr[k]);
    for (int j = 0; j < LANES; j++) begin
      int s;
      s = (j + int'(rot_amt)) % LANES;
      chk("R5 lane rotate", int'(vec_out[j*DW +: DW]), int'(rd_data[s*DW +: DW]));
      if (m_valid == 1)
        chk("R8 element order", int'(vec_out[j*DW +: DW]),
            m_mode ? (j * 16 + m_idx) : (m_idx * 16 + j));
    end
  end

  task automatic req(input logic md, input int ix);
    @(negedge clk);
    start = 1'b1; mode = md; idx = IW'(ix);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    for (int r = 0; r < LANES; r++) req(1'b0, r);
    idle(2);
    for (int c = 0; c < LANES; c++) begin req(1'b1, c); idle(1); end
    @(negedge clk);
    start = 1'b1;
    for (int n = 0; n < 2 * LANES; n++) begin
      mode = n[0]; idx = IW'(LANES - 1 - (n % LANES));
      @(negedge clk);
    end
    start = 1'b0;
    idle(3);
    req(1'b1, 3);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    req(1'b0, 2);
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule